// File: doc/BRIEF.md
# Three-level virtual-to-physical page table walker

This block turns a 39-bit virtual address into a 56-bit physical address by walking a three-level radix page table stored in memory. A caller raises a start strobe together with the virtual address, the physical base of the root table, the access kind, the privilege mode and two permission-relaxing flags. The walker then issues one 8-byte read per table level through a valid/ready request port. It takes each response as it arrives, and it either descends to the next table or stops at a leaf.

A walk ends with a one-cycle completion pulse. A successful walk returns the physical address, the leaf entry, the address that entry was read from, the level where the leaf was found and the accumulated global flag. A failed walk returns a fault code instead. Large leaves found above the last level map 2 MiB or 1 GiB regions. Their low page-number bits must be zero, and in the result those bits are filled from the virtual address. Only one walk is in flight at a time. A busy output covers the whole walk, and starts raised during it are ignored.

Top module: `pt_walker`

## Requirements
- R1: After reset `busy`, `memReqValid` and `doneValid` are low.
- R2: A walk starts at level 2. The first read address is the root base plus 8 times the virtual page number bits [26:18] (virtual address bits [38:30]). At level L the index is virtual page number bits [9L+8:9L]. Exactly one read is issued per level visited.
- R3: An entry layout has bit0 valid, bit1 readable, bit2 writable, bit3 executable, bit4 user, bit5 global, and the page number in bits [53:10]. A valid entry with bits 3:1 all zero points to a further table. That table's base is the entry's page number shifted left by 12, and the walk continues one level lower.
- R4: An entry with valid clear, or with writable set and readable clear, ends the walk with fault code 1. So does a pointer entry found at level 0.
- R5: A leaf fails with fault code 2 if any of these holds:
  - in user mode (`privUser`=1) its user bit is clear;
  - in supervisor mode its user bit is set, unless `sumEn` is set and the access is not an execute;
  - the access kind (`accKind` 0 read, 1 write, 2 execute) needs rights the leaf lacks. A read needs readable, or executable with `mxrEn`. A write needs writable. An execute needs executable.
- R6: A leaf at level L>0 whose page number has any of its low 9L bits set fails with fault code 3.
- R7: A successful walk reports fault code 0 with `doneOk` high. `physAddr` is {leaf page number OR (virtual page number AND low-9L mask), virtual address bits [11:0]}. `leafPte`, `pteAddr` and `leafLevel` are also reported.
- R8: `globalOut` is the OR of the global bits of every entry read on the path, the leaf included.
- R9: A read response with `memRspErr` high ends the walk with fault code 4.
- R10: `busy` rises the cycle after an accepted start and falls when `doneValid` pulses for one cycle. A start while busy changes nothing.
- R11: While `memReqValid` is high and `memReqReady` low, the request and its address are held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Begin a walk (taken only when idle) |
| vaddr | input | 39 | Virtual address to translate |
| rootBase | input | 56 | Physical base of the top-level table |
| accKind | input | 2 | 0 read, 1 write, 2 execute |
| privUser | input | 1 | 1 user mode, 0 supervisor mode |
| mxrEn | input | 1 | Let executable pages satisfy reads |
| sumEn | input | 1 | Let supervisor reads and writes touch user pages |
| busy | output | 1 | Walk in progress |
| memReqValid | output | 1 | Table entry read request |
| memReqReady | input | 1 | Memory accepts the request |
| memReqAddr | output | 56 | Address of the entry being read |
| memRspValid | input | 1 | Read data returned |
| memRspErr | input | 1 | Returned read failed |
| memRspData | input | 64 | Returned table entry |
| doneValid | output | 1 | One-cycle completion pulse |
| doneOk | output | 1 | Walk succeeded |
| faultCode | output | 3 | 0 none, 1 invalid entry, 2 permission, 3 misaligned leaf, 4 access fault |
| physAddr | output | 56 | Translated address |
| leafPte | output | 64 | Leaf entry found |
| pteAddr | output | 56 | Address of the final entry read |
| leafLevel | output | 2 | Level of that entry |
| globalOut | output | 1 | Accumulated global flag |

## Verification
The hardest cases to reach are the ones that need a specific chain of entries in memory. These include a misaligned leaf at level 1 reached through a pointer, a pointer entry at level 0, and a response error in the middle of a walk. The bench's memory model answers each read from a sparse table. Directed cases fill that table with exact chains. Random walks fill it on demand with freshly drawn entries, biased toward pointers, aligned page numbers and occasional errors. A start raised mid-walk with a different address checks that the first walk finishes unchanged.

// File: rtl/ptw_pkg.sv
`timescale 1ns/1ps
package ptw_pkg;
  typedef enum logic [2:0] {
    FLT_NONE    = 3'd0,
    FLT_INVALID = 3'd1,
    FLT_PERM    = 3'd2,
    FLT_ALIGN   = 3'd3,
    FLT_ACCESS  = 3'd4
  } faultT;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2
  } accT;

  // strobes from control to datapath
  typedef struct packed {
    logic  load;
    logic  descend;
    logic  finish;
    faultT code;
  } stepT;

  // classification of the entry currently on the response bus
  typedef struct packed {
    logic invalid;
    logic pointer;
    logic permOk;
    logic misaligned;
    logic lastLevel;
  } verdictT;
endpackage

// File: rtl/ptw_ctrl.sv
`timescale 1ns/1ps
module ptw_ctrl import ptw_pkg::*; (
  input  logic    clk,
  input  logic    rstN,
  input  logic    startReq,
  input  logic    memReqReady,
  input  logic    memRspValid,
  input  logic    memRspErr,
  input  verdictT verdict,
  output stepT    step,
  output logic    memReqValid,
  output logic    busy,
  output logic    doneValid
);
  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} stateT;
  stateT state, stateNext;

  always_comb begin
    step      = '0;
    step.code = FLT_NONE;
    stateNext = state;
    unique case (state)
      S_IDLE: if (startReq) begin
        step.load = 1'b1;
        stateNext = S_REQ;
      end
      S_REQ: if (memReqReady) stateNext = S_WAIT;
      S_WAIT: if (memRspValid) begin
        if (memRspErr) begin
          step.finish = 1'b1;
          step.code   = FLT_ACCESS;
        end else if (verdict.invalid) begin
          step.finish = 1'b1;
          step.code   = FLT_INVALID;
        end else if (verdict.pointer) begin
          if (verdict.lastLevel) begin
            step.finish = 1'b1;
            step.code   = FLT_INVALID;
          end else begin
            step.descend = 1'b1;
          end
        end else if (!verdict.permOk) begin
          step.finish = 1'b1;
          step.code   = FLT_PERM;
        end else if (verdict.misaligned) begin
          step.finish = 1'b1;
          step.code   = FLT_ALIGN;
        end else begin
          step.finish = 1'b1;
        end
        stateNext = step.finish ? S_IDLE : S_REQ;
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_IDLE;
      doneValid <= 1'b0;
    end else begin
      state     <= stateNext;
      doneValid <= step.finish;
    end
  end

  assign memReqValid = (state == S_REQ);
  assign busy        = (state != S_IDLE);
endmodule

// File: rtl/ptw_dpath.sv
`timescale 1ns/1ps
module ptw_dpath import ptw_pkg::*; #(
  parameter int LEVELS   = 3,
  parameter int LVL_BITS = 9,
  parameter int OFS_W    = 12,
  parameter int PPN_W    = 44,
  parameter int PTE_W    = 64,
  localparam int VPN_W     = LEVELS * LVL_BITS,
  localparam int VA_W      = VPN_W + OFS_W,
  localparam int PA_W      = PPN_W + OFS_W,
  localparam int LVL_W     = $clog2(LEVELS),
  localparam int PTE_SHIFT = $clog2(PTE_W / 8)
) (
  input  logic             clk,
  input  logic             rstN,
  input  stepT             step,
  input  logic [VA_W-1:0]  vaddr,
  input  logic [PA_W-1:0]  rootBase,
  input  logic [1:0]       accKind,
  input  logic             privUser,
  input  logic             mxrEn,
  input  logic             sumEn,
  input  logic [PTE_W-1:0] memRspData,
  output logic [PA_W-1:0]  memReqAddr,
  output verdictT          verdict,
  output logic             doneOk,
  output logic [2:0]       faultCode,
  output logic [PA_W-1:0]  physAddr,
  output logic [PTE_W-1:0] leafPte,
  output logic [PA_W-1:0]  pteAddr,
  output logic [LVL_W-1:0] leafLevel,
  output logic             globalOut
);
  localparam int PPN_LSB = 10;

  logic [VA_W-1:0]  vaR;
  logic [PA_W-1:0]  baseR;
  logic [LVL_W-1:0] lvlR;
  accT              accR;
  logic             userR, mxrR, sumR, globR;

  logic [VPN_W-1:0] vpn;
  assign vpn = vaR[VA_W-1:OFS_W];

  logic [LVL_BITS-1:0] idxByLvl  [LEVELS];
  logic [PPN_W-1:0]    maskByLvl [LEVELS];
  for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
    assign idxByLvl[g]  = vpn[g*LVL_BITS +: LVL_BITS];
    assign maskByLvl[g] = (PPN_W'(1) << (g * LVL_BITS)) - PPN_W'(1);
  end

  logic [LVL_BITS-1:0] idxCur;
  logic [PPN_W-1:0]    lvlMask, ppn, finalPpn;
  assign idxCur     = idxByLvl[lvlR];
  assign lvlMask    = maskByLvl[lvlR];
  assign memReqAddr = baseR + PA_W'({idxCur, {PTE_SHIFT{1'b0}}});

  logic pV, pR, pW, pX, pU, pG, globNew, privOk, kindOk;
  assign {pG, pU, pX, pW, pR, pV} = memRspData[5:0];
  assign ppn      = memRspData[PPN_LSB +: PPN_W];
  assign finalPpn = ppn | (PPN_W'(vpn) & lvlMask);
  assign globNew  = globR | pG;

  always_comb begin
    if (userR) privOk = pU;
    else       privOk = !pU || (sumR && accR != ACC_EXEC);
    unique case (accR)
      ACC_READ:  kindOk = pR || (pX && mxrR);
      ACC_WRITE: kindOk = pW;
      ACC_EXEC:  kindOk = pX;
      default:   kindOk = 1'b0;
    endcase
  end

  assign verdict.invalid    = !pV || (pW && !pR);
  assign verdict.pointer    = !(pR || pW || pX);
  assign verdict.permOk     = privOk && kindOk;
  assign verdict.misaligned = |(ppn & lvlMask);
  assign verdict.lastLevel  = (lvlR == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaR <= '0; baseR <= '0; lvlR <= '0; accR <= ACC_READ;
      userR <= 1'b0; mxrR <= 1'b0; sumR <= 1'b0; globR <= 1'b0;
      doneOk <= 1'b0; faultCode <= '0; physAddr <= '0; leafPte <= '0;
      pteAddr <= '0; leafLevel <= '0; globalOut <= 1'b0;
    end else begin
      if (step.load) begin
        vaR   <= vaddr;
        baseR <= rootBase;
        lvlR  <= LVL_W'(LEVELS - 1);
        accR  <= accT'(accKind);
        userR <= privUser;
        mxrR  <= mxrEn;
        sumR  <= sumEn;
        globR <= 1'b0;
      end
      if (step.descend) begin
        baseR <= {ppn, {OFS_W{1'b0}}};
        lvlR  <= lvlR - LVL_W'(1);
        globR <= globNew;
      end
      if (step.finish) begin
        faultCode <= step.code;
        doneOk    <= (step.code == FLT_NONE);
        physAddr  <= {finalPpn, vaR[OFS_W-1:0]};
        leafPte   <= memRspData;
        pteAddr   <= memReqAddr;
        leafLevel <= lvlR;
        globalOut <= globNew;
      end
    end
  end
endmodule

// File: rtl/pt_walker.sv
`timescale 1ns/1ps
module pt_walker import ptw_pkg::*; #(
  parameter int LEVELS   = 3,
  parameter int LVL_BITS = 9,
  parameter int OFS_W    = 12,
  parameter int PPN_W    = 44,
  parameter int PTE_W    = 64,
  localparam int VA_W  = LEVELS * LVL_BITS + OFS_W,
  localparam int PA_W  = PPN_W + OFS_W,
  localparam int LVL_W = $clog2(LEVELS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic [VA_W-1:0]  vaddr,
  input  logic [PA_W-1:0]  rootBase,
  input  logic [1:0]       accKind,
  input  logic             privUser,
  input  logic             mxrEn,
  input  logic             sumEn,
  output logic             busy,
  output logic             memReqValid,
  input  logic             memReqReady,
  output logic [PA_W-1:0]  memReqAddr,
  input  logic             memRspValid,
  input  logic             memRspErr,
  input  logic [PTE_W-1:0] memRspData,
  output logic             doneValid,
  output logic             doneOk,
  output logic [2:0]       faultCode,
  output logic [PA_W-1:0]  physAddr,
  output logic [PTE_W-1:0] leafPte,
  output logic [PA_W-1:0]  pteAddr,
  output logic [LVL_W-1:0] leafLevel,
  output logic             globalOut
);
  stepT    step;
  verdictT verdict;

  ptw_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq),
    .memReqReady(memReqReady), .memRspValid(memRspValid), .memRspErr(memRspErr),
    .verdict(verdict), .step(step), .memReqValid(memReqValid),
    .busy(busy), .doneValid(doneValid)
  );

  ptw_dpath #(
    .LEVELS(LEVELS), .LVL_BITS(LVL_BITS), .OFS_W(OFS_W), .PPN_W(PPN_W), .PTE_W(PTE_W)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .step(step), .vaddr(vaddr), .rootBase(rootBase),
    .accKind(accKind), .privUser(privUser), .mxrEn(mxrEn), .sumEn(sumEn),
    .memRspData(memRspData), .memReqAddr(memReqAddr), .verdict(verdict),
    .doneOk(doneOk), .faultCode(faultCode), .physAddr(physAddr), .leafPte(leafPte),
    .pteAddr(pteAddr), .leafLevel(leafLevel), .globalOut(globalOut)
  );
endmodule

// File: rtl/pt_walker_chk.sv
`timescale 1ns/1ps
module pt_walker_chk #(
  parameter int PA_W = 56
) (
  input logic            clk,
  input logic            rstN,
  input logic            startReq,
  input logic            busy,
  input logic            memReqValid,
  input logic            memReqReady,
  input logic [PA_W-1:0] memReqAddr,
  input logic            memRspValid,
  input logic            memRspErr,
  input logic            doneValid,
  input logic [2:0]      faultCode
);
  a_r10_busy_after_start: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && startReq) |=> busy);
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);
  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> !busy);
  a_r11_req_hold: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> (memReqValid && $stable(memReqAddr)));
  a_r9_access_fault: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !memReqValid && memRspValid && memRspErr) |=> (doneValid && faultCode == 3'd4));
  a_r2_no_req_idle: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memReqValid);
  a_r4_code_range: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> (faultCode <= 3'd4));
endmodule

bind pt_walker pt_walker_chk #(.PA_W(PA_W)) u_chk (
  .clk(clk), .rstN(rstN), .startReq(startReq), .busy(busy),
  .memReqValid(memReqValid), .memReqReady(memReqReady), .memReqAddr(memReqAddr),
  .memRspValid(memRspValid), .memRspErr(memRspErr), .doneValid(doneValid),
  .faultCode(faultCode)
);

// File: tb/pt_walker_bench.sv
`timescale 1ns/1ps
module pt_walker_bench;
  logic clk = 1'b0, rstN = 1'b0;
  logic startReq = 0, privUser = 0, mxrEn = 0, sumEn = 0;
  logic [38:0] vaddr = '0;
  logic [55:0] rootBase = '0;
  logic [1:0]  accKind = '0;
  logic memReqReady = 0, memRspValid = 0, memRspErr = 0;
  logic [63:0] memRspData = '0;
  logic busy, memReqValid, doneValid, doneOk, globalOut;
  logic [55:0] memReqAddr, physAddr, pteAddr;
  logic [63:0] leafPte;
  logic [2:0]  faultCode;
  logic [1:0]  leafLevel;

  int checks = 0, errors = 0;
  bit randFill = 0;
  logic [63:0] mem    [logic [55:0]];
  bit          errSet [logic [55:0]];

  always #10 clk = ~clk;

  pt_walker u_pt_walker (
    .clk(clk), .rstN(rstN), .startReq(startReq), .vaddr(vaddr), .rootBase(rootBase),
    .accKind(accKind), .privUser(privUser), .mxrEn(mxrEn), .sumEn(sumEn),
    .busy(busy), .memReqValid(memReqValid), .memReqReady(memReqReady),
    .memReqAddr(memReqAddr), .memRspValid(memRspValid), .memRspErr(memRspErr),
    .memRspData(memRspData), .doneValid(doneValid), .doneOk(doneOk),
    .faultCode(faultCode), .physAddr(physAddr), .leafPte(leafPte), .pteAddr(pteAddr),
    .leafLevel(leafLevel), .globalOut(globalOut)
  );

  localparam logic [7:0] FV = 8'h01, FR = 8'h02, FW = 8'h04, FX = 8'h08, FU = 8'h10, FG = 8'h20;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] mkPte(input logic [43:0] ppn, input logic [7:0] fl);
    return {10'b0, ppn, 2'b0, fl};
  endfunction

  function automatic logic [63:0] genPte();
    logic [43:0] ppn;
    logic [7:0]  fl;
    int k;
    ppn = {$urandom, $urandom};
    if ($urandom % 2 == 0) ppn[17:0] = '0;
    fl = 8'($urandom) & 8'hF0;
    if ($urandom % 3 != 0) fl[5] = 1'b0;
    k = int'($urandom % 12);
    if (k == 0)      fl[3:0] = 4'($urandom) & 4'hE;
    else if (k == 1) fl[3:0] = 4'b0101 | (4'($urandom) & 4'h8);
    else if (k < 6)  fl[3:0] = 4'b0001;
    else case ($urandom % 5)
      0: fl[3:0] = 4'b0011;
      1: fl[3:0] = 4'b0111;
      2: fl[3:0] = 4'b1011;
      3: fl[3:0] = 4'b1111;
      default: fl[3:0] = 4'b1001;
    endcase
    return mkPte(ppn, fl);
  endfunction

  // independent model of the walk
  function automatic void refWalk(input logic [38:0] va, input logic [55:0] root, input logic [1:0] acc,
      input logic u, input logic m, input logic s,
      output logic [2:0] code, output logic [55:0] pa, output logic [63:0] pte,
      output logic [55:0] lastA, output logic [1:0] lvlO, output logic gl,
      output int n, output logic [2:0][55:0] ea);
    logic [55:0] base, a;
    logic [43:0] ppn, msk;
    logic [26:0] vpn;
    logic [8:0]  idx;
    logic [63:0] p;
    int lvl;
    bit allowed;
    base = root; lvl = 2; gl = 0; n = 0; ea = '0;
    code = 0; pa = '0; pte = '0; lastA = '0; lvlO = '0;
    vpn = va[38:12];
    for (int step = 0; step < 3; step++) begin
      idx = 9'(vpn >> (lvl * 9));
      a = base + {44'd0, idx, 3'b000};
      ea[n] = a; n++;
      lastA = a; lvlO = 2'(lvl);
      if (errSet.exists(a) && errSet[a]) begin code = 4; return; end
      p = mem.exists(a) ? mem[a] : 64'd0;
      pte = p;
      gl = gl | p[5];
      if (p[0] == 0 || (p[2] && !p[1])) begin code = 1; return; end
      ppn = p[53:10];
      if (p[3:1] == 3'b000) begin
        if (lvl == 0) begin code = 1; return; end
        base = {ppn, 12'h000};
        lvl--;
        continue;
      end
      if (u) allowed = p[4];
      else allowed = (p[4] == 0) || (s && acc != 2);
      if (acc == 0)      allowed = allowed && (p[1] || (m && p[3]));
      else if (acc == 1) allowed = allowed && p[2];
      else               allowed = allowed && p[3];
      if (!allowed) begin code = 2; return; end
      msk = '0;
      for (int i = 0; i < lvl * 9; i++) msk[i] = 1'b1;
      if ((ppn & msk) != 0) begin code = 3; return; end
      pa = {ppn | ({17'd0, vpn} & msk), va[11:0]};
      return;
    end
  endfunction

  task automatic runWalk(input logic [38:0] va, input logic [55:0] root, input logic [1:0] acc,
      input logic u, input logic m, input logic s, input bit poke, input int expCode);
    logic [2:0] eCode; logic [55:0] ePa, eLastA; logic [63:0] ePte; logic [1:0] eLvl;
    logic eGl; int eN; logic [2:0][55:0] eA;
    logic [55:0] obs [3];
    logic [55:0] a, hold;
    int nObs = 0, guard = 0;
    bit fin = 0;
    @(negedge clk);
    vaddr = va; rootBase = root; accKind = acc; privUser = u; mxrEn = m; sumEn = s; startReq = 1;
    @(negedge clk);
    startReq = 0;
    check(busy === 1'b1, "R10 busy after start", 64'(busy), 64'd1);
    if (poke) begin
      memReqReady = 0;
      startReq = 1; vaddr = ~va; rootBase = root ^ 56'h1000;
      @(negedge clk);
      startReq = 0; vaddr = va; rootBase = root;
    end
    while (!fin && guard < 200) begin
      guard++;
      if (doneValid) fin = 1;
      else if (memReqValid) begin
        if ($urandom % 3 == 0) begin
          memReqReady = 0; hold = memReqAddr;
          @(negedge clk);
          check(memReqValid === 1'b1 && memReqAddr === hold, "R11 request held",
                64'(memReqAddr), 64'(hold));
        end else begin
          memReqReady = 1; a = memReqAddr;
          if (nObs < 3) obs[nObs] = a;
          nObs++;
          if (randFill && !mem.exists(a)) begin
            mem[a] = genPte();
            errSet[a] = ($urandom % 16 == 0);
          end
          @(negedge clk);
          memReqReady = 0;
          repeat ($urandom % 3) @(negedge clk);
          memRspValid = 1;
          memRspData = mem.exists(a) ? mem[a] : 64'd0;
          memRspErr = errSet.exists(a) ? errSet[a] : 1'b0;
          @(negedge clk);
          memRspValid = 0; memRspErr = 0; memRspData = {$urandom, $urandom};
        end
      end else @(negedge clk);
    end
    check(fin, "R10 walk completes", 64'(fin), 64'd1);
    refWalk(va, root, acc, u, m, s, eCode, ePa, ePte, eLastA, eLvl, eGl, eN, eA);
    check(nObs == eN, "R2 read count", 64'(nObs), 64'(eN));
    for (int i = 0; i < 3; i++)
      if (i < eN && i < nObs) check(obs[i] === eA[i], "R2/R3 read address", 64'(obs[i]), 64'(eA[i]));
    check(faultCode === eCode, "R4/R5/R6/R9 fault code", 64'(faultCode), 64'(eCode));
    if (expCode >= 0) check(faultCode === 3'(expCode), "directed fault code", 64'(faultCode), 64'(expCode));
    check(doneOk === (eCode == 0), "R7 doneOk", 64'(doneOk), 64'(eCode == 0));
    if (eCode == 0) begin
      check(physAddr === ePa, "R7 physAddr", 64'(physAddr), 64'(ePa));
      check(leafPte === ePte, "R7 leafPte", leafPte, ePte);
      check(pteAddr === eLastA, "R7 pteAddr", 64'(pteAddr), 64'(eLastA));
      check(leafLevel === eLvl, "R7 leafLevel", 64'(leafLevel), 64'(eLvl));
      check(globalOut === eGl, "R8 globalOut", 64'(globalOut), 64'(eGl));
    end
    @(negedge clk);
    check(doneValid === 1'b0 && busy === 1'b0, "R10 pulse ends idle", 64'({doneValid, busy}), 64'd0);
  endtask

  task automatic clearMem();
    mem.delete();
    errSet.delete();
  endtask

  localparam logic [55:0] ROOT = 56'h0000_0010_0000;
  localparam logic [38:0] VA   = {9'd1, 9'd2, 9'd3, 12'hABC};

  task automatic oneLeaf(input logic [7:0] fl, input logic [1:0] acc, input logic u,
                         input logic m, input logic s, input int exp);
    clearMem();
    mem[ROOT + 56'd8] = mkPte(44'h40000, fl);
    runWalk(VA, ROOT, acc, u, m, s, 0, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(busy === 0 && memReqValid === 0 && doneValid === 0, "R1 reset state",
          64'({busy, memReqValid, doneValid}), 64'd0);
    rstN = 1;
    // R3 R8: three-level walk, global set only on the top pointer
    clearMem();
    mem[ROOT + 56'd8]            = mkPte(44'h200, FV | FG);
    mem[56'h200000 + 56'd16]     = mkPte(44'h300, FV);
    mem[56'h300000 + 56'd24]     = mkPte(44'h12345, FV | FR | FW);
    runWalk(VA, ROOT, 0, 0, 0, 0, 0, 0);
    check(physAddr === {44'h12345, 12'hABC}, "R7 4K page", 64'(physAddr), 64'({44'h12345, 12'hABC}));
    check(globalOut === 1'b1, "R8 global carried", 64'(globalOut), 64'd1);
    // R10: start raised while busy is ignored
    runWalk(VA, ROOT, 1, 0, 0, 0, 1, 0);
    check(physAddr === {44'h12345, 12'hABC}, "R10 mid-walk start ignored", 64'(physAddr), 64'({44'h12345, 12'hABC}));
    // R7: aligned 1G leaf at level 2, low bits spliced from virtual page number
    oneLeaf(FV | FR | FX, 0, 0, 0, 0, 0);
    check(physAddr === {44'h40403, 12'hABC}, "R7 1G splice", 64'(physAddr), 64'({44'h40403, 12'hABC}));
    check(leafLevel === 2'd2, "R7 leaf level 2", 64'(leafLevel), 64'd2);
    // R6: misaligned 2M leaf
    clearMem();
    mem[ROOT + 56'd8]        = mkPte(44'h200, FV);
    mem[56'h200000 + 56'd16] = mkPte(44'h401, FV | FR);
    runWalk(VA, ROOT, 0, 0, 0, 0, 0, 3);
    // R4: pointer at level 0 and write-without-read entry
    clearMem();
    mem[ROOT + 56'd8]        = mkPte(44'h200, FV);
    mem[56'h200000 + 56'd16] = mkPte(44'h300, FV);
    mem[56'h300000 + 56'd24] = mkPte(44'h500, FV);
    runWalk(VA, ROOT, 0, 0, 0, 0, 0, 1);
    oneLeaf(FV | FW, 1, 0, 0, 0, 1);
    oneLeaf(FR | FW, 0, 0, 0, 0, 1);
    // R5: permission rules
    oneLeaf(FV | FR, 0, 1, 0, 0, 2);
    oneLeaf(FV | FR | FU, 0, 0, 0, 0, 2);
    oneLeaf(FV | FR | FU, 0, 0, 0, 1, 0);
    oneLeaf(FV | FR | FX | FU, 2, 0, 0, 1, 2);
    oneLeaf(FV | FX, 0, 0, 0, 0, 2);
    oneLeaf(FV | FX, 0, 0, 1, 0, 0);
    oneLeaf(FV | FR, 1, 0, 0, 0, 2);
    oneLeaf(FV | FR | FU, 2, 1, 0, 0, 2);
    // R9: access fault at the top and at the middle level
    clearMem();
    errSet[ROOT + 56'd8] = 1;
    runWalk(VA, ROOT, 0, 0, 0, 0, 0, 4);
    clearMem();
    mem[ROOT + 56'd8] = mkPte(44'h200, FV);
    errSet[56'h200000 + 56'd16] = 1;
    runWalk(VA, ROOT, 0, 0, 0, 0, 0, 4);
    // random walks over tables filled on demand
    randFill = 1;
    void'($urandom(32'd1234));
    for (int i = 0; i < 300; i++) begin
      clearMem();
      runWalk(39'({$urandom, $urandom}), {32'($urandom), 12'h000} & 56'h00FF_FFFF_FFFF_F000,
              2'($urandom % 3), 1'($urandom), 1'($urandom), 1'($urandom), ($urandom % 8 == 0), -1);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule